// File: doc/BRIEF.md
# Checksum-Protected Linear Shift Register

This block is a linear feedback shift register over GF(2) with one extra state bit that carries a running checksum. On every clock it takes a one-bit input and computes the next value of each of the D register bits. Each bit has its own small network of two-input XOR gates. Because the feedback matrix has the companion (Galois) shape, a bit depends on at most one neighbouring bit, the top bit and the input. The extra bit is updated in the same loop so that, without faults, it always equals the XOR of the D register bits. A single failing gate corrupts exactly one bit of the next state, so it breaks that parity relation.

A registered checker flags every cycle in which the XOR of all D+1 state bits is odd. It does not repair the state. A test port XORs an arbitrary mask into the computed next state, so faults can be injected on purpose. A parameter selects how the checksum bit is produced. The full form rebuilds it from the register bits. The recursive form folds in its own previous value and needs fewer gates. The two forms behave the same when no fault occurs, but they react differently once a fault has happened.

Top module: `lfsr_cs_top`

## Requirements
- R1: While `rst` is high at a rising edge, the register loads `SEED` (default 5'b00001), the checksum bit loads the XOR of `SEED`'s bits, and `err_o` goes low.
- R2: With no fault injected, the next register value is computed per bit i as (bit i-1, or 0 for i=0) XOR (`TAPS[i]` AND bit D-1) XOR (`IN_VEC[i]` AND `din`). The defaults are `TAPS`=5'b00101 and `IN_VEC`=5'b00001.
- R3: Without injected faults, starting from reset, the checksum bit equals the XOR of the D register bits in every cycle.
- R4: `err_o` is high in exactly those cycles where the XOR of `state_o` and `chk_o` is 1. It is registered together with the state it describes.
- R5: `fault_mask` bit i (bits 0..D-1 for register bits, bit D for the checksum) inverts that bit of the value loaded at the next edge. Later updates start from the corrupted value, and no correction is made.
- R6: A single-bit fault applied while `err_o` is low raises `err_o` in the cycle the corrupted state appears. A fault that inverts an even number of bits is not flagged.
- R7: With `din` held at 0 and the default seed and taps, the register steps through all 31 nonzero values and returns to the seed after 31 clocks.
- R8: With `CHK_MODE` = full, `err_o` drops in the first fault-free update after a fault. With `CHK_MODE` = recursive, a parity violation persists through every fault-free update until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial input bit |
| fault_mask | input | D+1 | Bits to invert in the next state; MSB is the checksum bit |
| state_o | output | D | Current register value |
| chk_o | output | 1 | Current checksum bit |
| err_o | output | 1 | Parity violation flag for the current state |

## Verification
A wrong register bit shows on `state_o` in the very cycle it is loaded. Because the checksum disagrees with it, it also raises `err_o` in that same cycle. In the full checksum form the flag lasts one cycle and only the register sequence carries the damage onward. In the recursive form the flag stays high, so a missed or spurious correction shows as `err_o` changing one cycle after the fault. Comparing both variants against an independent cycle model on every clock separates these behaviours.

// File: rtl/lfsr_cs_pkg.sv
package lfsr_cs_pkg;

  typedef enum logic {
    CHK_FULL  = 1'b0,
    CHK_RECUR = 1'b1
  } chk_mode_e;

endpackage

// File: rtl/lfsr_cs_bit_net.sv
// One next-state bit: a private chain of 2-input XOR gates.
module lfsr_cs_bit_net #(
  parameter bit HAS_PREV = 1'b1,
  parameter bit HAS_TAP  = 1'b0,
  parameter bit HAS_IN   = 1'b0
) (
  input  logic prev_bit,
  input  logic fb_bit,
  input  logic din,
  output logic nxt_o
);
  logic term_prev;
  logic term_fb;
  logic term_in;
  logic stage1;

  assign term_prev = HAS_PREV ? prev_bit : 1'b0;
  assign term_fb   = HAS_TAP  ? fb_bit   : 1'b0;
  assign term_in   = HAS_IN   ? din      : 1'b0;
  assign stage1    = term_prev ^ term_fb;
  assign nxt_o     = stage1 ^ term_in;
endmodule

// File: rtl/lfsr_cs_sum_net.sv
// Next value of the checksum bit, full or recursive form.
module lfsr_cs_sum_net #(
  parameter int                     D        = 5,
  parameter logic [D-1:0]           TAPS     = 5'b00101,
  parameter logic [D-1:0]           IN_VEC   = 5'b00001,
  parameter lfsr_cs_pkg::chk_mode_e CHK_MODE = lfsr_cs_pkg::CHK_FULL
) (
  input  logic [D-1:0] state_i,
  input  logic         chk_i,
  input  logic         din,
  output logic         chk_nxt_o
);
  // column sums of the feedback matrix and of the input vector
  localparam logic TOP_COL = ^TAPS;
  localparam logic IN_SUM  = ^IN_VEC;

  logic in_term;
  assign in_term = IN_SUM & din;

  generate
    if (CHK_MODE == lfsr_cs_pkg::CHK_FULL) begin : g_full
      logic low_sum;
      logic top_term;
      assign low_sum   = ^state_i[D-2:0];
      assign top_term  = TOP_COL & state_i[D-1];
      assign chk_nxt_o = low_sum ^ top_term ^ in_term;
      logic unused_chk;
      assign unused_chk = chk_i;
    end else begin : g_recur
      localparam logic TOP_DELTA = TOP_COL ^ 1'b1;
      logic top_term;
      assign top_term  = TOP_DELTA & state_i[D-1];
      assign chk_nxt_o = chk_i ^ top_term ^ in_term;
      logic unused_low;
      assign unused_low = ^state_i[D-2:0];
    end
  endgenerate
endmodule

// File: rtl/lfsr_cs_parity.sv
module lfsr_cs_parity #(
  parameter int W = 6
) (
  input  logic [W-1:0] word_i,
  output logic         odd_o
);
  assign odd_o = ^word_i;
endmodule

// File: rtl/lfsr_cs_top.sv
module lfsr_cs_top #(
  parameter int                     D        = 5,
  parameter logic [D-1:0]           TAPS     = 5'b00101,
  parameter logic [D-1:0]           IN_VEC   = 5'b00001,
  parameter logic [D-1:0]           SEED     = 5'b00001,
  parameter lfsr_cs_pkg::chk_mode_e CHK_MODE = lfsr_cs_pkg::CHK_FULL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  input  logic [D:0]   fault_mask,
  output logic [D-1:0] state_o,
  output logic         chk_o,
  output logic         err_o
);
  localparam int   W        = D + 1;
  localparam logic SEED_SUM = ^SEED;

  logic [D-1:0] state_q;
  logic         chk_q;
  logic         err_q;
  logic [D:0]   prev_pad;
  logic [D-1:0] nxt_raw;
  logic         chk_raw;
  logic [W-1:0] nxt_word;
  logic         nxt_odd;

  assign prev_pad = {state_q, 1'b0};

  genvar gi;
  generate
    for (gi = 0; gi < D; gi++) begin : g_bit
      lfsr_cs_bit_net #(
        .HAS_PREV(gi > 0),
        .HAS_TAP (TAPS[gi]),
        .HAS_IN  (IN_VEC[gi])
      ) u_net (
        .prev_bit(prev_pad[gi]),
        .fb_bit  (state_q[D-1]),
        .din     (din),
        .nxt_o   (nxt_raw[gi])
      );
    end
  endgenerate

  lfsr_cs_sum_net #(
    .D       (D),
    .TAPS    (TAPS),
    .IN_VEC  (IN_VEC),
    .CHK_MODE(CHK_MODE)
  ) u_sum (
    .state_i  (state_q),
    .chk_i    (chk_q),
    .din      (din),
    .chk_nxt_o(chk_raw)
  );

  assign nxt_word = {chk_raw, nxt_raw} ^ fault_mask;

  lfsr_cs_parity #(.W(W)) u_par (
    .word_i(nxt_word),
    .odd_o (nxt_odd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
      chk_q   <= SEED_SUM;
      err_q   <= 1'b0;
    end else begin
      state_q <= nxt_word[D-1:0];
      chk_q   <= nxt_word[D];
      err_q   <= nxt_odd;
    end
  end

  assign state_o = state_q;
  assign chk_o   = chk_q;
  assign err_o   = err_q;
endmodule

// File: rtl/lfsr_cs_chk.sv
module lfsr_cs_chk #(
  parameter int                     D        = 5,
  parameter logic [D-1:0]           TAPS     = 5'b00101,
  parameter logic [D-1:0]           IN_VEC   = 5'b00001,
  parameter logic [D-1:0]           SEED     = 5'b00001,
  parameter lfsr_cs_pkg::chk_mode_e CHK_MODE = lfsr_cs_pkg::CHK_FULL
) (
  input logic         clk,
  input logic         rst,
  input logic         din,
  input logic [D:0]   fault_mask,
  input logic [D-1:0] state_o,
  input logic         chk_o,
  input logic         err_o
);
  logic         rst_d;
  logic [D-1:0] exp_nxt;

  always_ff @(posedge clk) rst_d <= rst;

  always_comb begin
    for (int i = 0; i < D; i++) begin
      exp_nxt[i] = (i > 0 ? state_o[(i > 0) ? i-1 : 0] : 1'b0)
                 ^ (TAPS[i] & state_o[D-1]) ^ (IN_VEC[i] & din) ^ fault_mask[i];
    end
  end

  always @(posedge clk) begin
    if (rst_d && !rst) begin
      AST_RESET_LOAD: assert (state_o == SEED && chk_o == ^SEED && !err_o); // R1
    end
  end

  AST_NEXT_STATE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> state_o == $past(exp_nxt)); // R2, R5

  AST_CLEAN_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!err_o && fault_mask == '0) |=> (chk_o == ^state_o)); // R3

  AST_ERR_PARITY: assert property (@(posedge clk) disable iff (rst)
    err_o == (chk_o ^ (^state_o))); // R4

  AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!err_o && $countones(fault_mask) == 1) |=> err_o); // R6

  AST_EVEN_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (!err_o && $countones(fault_mask) == 2) |=> !err_o); // R6

  generate
    if (CHK_MODE == lfsr_cs_pkg::CHK_FULL) begin : g_full
      AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (fault_mask == '0) |=> !err_o); // R8
    end else begin : g_recur
      AST_RECUR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (err_o && fault_mask == '0) |=> err_o); // R8
    end
  endgenerate
endmodule

bind lfsr_cs_top lfsr_cs_chk #(
  .D(D), .TAPS(TAPS), .IN_VEC(IN_VEC), .SEED(SEED), .CHK_MODE(CHK_MODE)
) u_chk (
  .clk(clk), .rst(rst), .din(din), .fault_mask(fault_mask),
  .state_o(state_o), .chk_o(chk_o), .err_o(err_o)
);

// File: tb/lfsr_cs_top_tb.sv
`timescale 1ns/1ps
module lfsr_cs_top_tb_top;
  localparam int         D  = 5;
  localparam logic [4:0] TP = 5'b00101;
  localparam logic [4:0] IV = 5'b00001;
  localparam logic [4:0] SD = 5'b00001;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [5:0] fault_mask = '0;
  logic [4:0] st_f, st_r;
  logic       ck_f, ck_r, er_f, er_r;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural models: full and recursive checksum
  logic [4:0] ms_f, ms_r;
  logic       mc_f, mc_r, me_f, me_r;
  int unsigned lcg = 32'd12345;

  always #10 clk = ~clk;

  lfsr_cs_top #(.D(D), .TAPS(TP), .IN_VEC(IV), .SEED(SD),
                .CHK_MODE(lfsr_cs_pkg::CHK_FULL)) dut_i (
    .clk(clk), .rst(rst), .din(din), .fault_mask(fault_mask),
    .state_o(st_f), .chk_o(ck_f), .err_o(er_f));

  lfsr_cs_top #(.D(D), .TAPS(TP), .IN_VEC(IV), .SEED(SD),
                .CHK_MODE(lfsr_cs_pkg::CHK_RECUR)) dut_r_i (
    .clk(clk), .rst(rst), .din(din), .fault_mask(fault_mask),
    .state_o(st_r), .chk_o(ck_r), .err_o(er_r));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check({st_f, ck_f, er_f} == {ms_f, mc_f, me_f}, tag, "full{state,chk,err}",
          {st_f, ck_f, er_f}, {ms_f, mc_f, me_f});
    check({st_r, ck_r, er_r} == {ms_r, mc_r, me_r}, tag, "recur{state,chk,err}",
          {st_r, ck_r, er_r}, {ms_r, mc_r, me_r});
  endtask

  function automatic logic [4:0] advance(input logic [4:0] s, input logic x);
    logic [4:0] n;
    n = {s[3:0], 1'b0};
    if (s[4]) n = n ^ TP;
    if (x)    n = n ^ IV;
    return n;
  endfunction

  task automatic do_reset();
    rst = 1'b1; din = 1'b0; fault_mask = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ms_f = SD; ms_r = SD; mc_f = ^SD; mc_r = ^SD; me_f = 1'b0; me_r = 1'b0;
    compare("R1");
  endtask

  task automatic step(input logic x, input logic [5:0] m, input string tag);
    logic [4:0] nf, nr;
    din = x; fault_mask = m;
    nf = advance(ms_f, x);
    nr = advance(ms_r, x);
    mc_f = (^nf) ^ m[5];
    mc_r = mc_r ^ (^nr) ^ (^ms_r) ^ m[5];
    ms_f = nf ^ m[4:0];
    ms_r = nr ^ m[4:0];
    me_f = mc_f ^ (^ms_f);
    me_r = mc_r ^ (^ms_r);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic rnd_bit();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[16];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen [32];
    int distinct;
    @(negedge clk);

    // R1: reset state
    do_reset();

    // R7: free run with zero input covers all nonzero states
    foreach (seen[i]) seen[i] = 0;
    distinct = 0;
    for (int k = 0; k < 31; k++) begin
      step(1'b0, 6'd0, "R2");
      if (st_f != 0 && !seen[st_f]) begin seen[st_f] = 1; distinct++; end
    end
    check(distinct == 31, "R7", "distinct states", distinct, 31);
    check(st_f == SD, "R7", "return to seed", st_f, SD);

    // R2/R3/R4: pseudo-random input, no faults
    do_reset();
    for (int k = 0; k < 40; k++) begin
      step(rnd_bit(), 6'd0, "R3");
      check(ck_f == ^st_f && !er_f, "R3", "full chk parity", ck_f, ^st_f);
    end

    // R5/R6/R8: single-bit fault on every position
    for (int b = 0; b < 6; b++) begin
      do_reset();
      for (int k = 0; k < 3; k++) step(rnd_bit(), 6'd0, "R4");
      step(rnd_bit(), 6'(1 << b), "R5");
      check(er_f && er_r, "R6", "single fault flagged", {er_f, er_r}, 2'b11);
      step(rnd_bit(), 6'd0, "R5");
      check(!er_f, "R8", "full form clears", er_f, 0);
      check(er_r, "R8", "recursive form holds", er_r, 1);
      step(rnd_bit(), 6'd0, "R8");
    end

    // R6: even-weight fault goes unnoticed
    do_reset();
    step(1'b1, 6'b000011, "R6");
    check(!er_f && !er_r, "R6", "double fault hidden", {er_f, er_r}, 2'b00);
    step(1'b0, 6'b100100, "R6");
    check(!er_f && !er_r, "R6", "chk+bit fault hidden", {er_f, er_r}, 2'b00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule